// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a 1024-word memory with two independent ports, called left and right. It watches the control and address lines of both ports and keeps two active-low interrupt flags so that one side can send a message to the other. Each port owns one reserved word at the top of the address space. A write by the opposite port into that word raises the owner's interrupt. The owner acknowledges by reading the same word, and this returns its interrupt line high.

All port signals are sampled on the rising edge of a common clock. A qualified access seen at an edge changes the flag at that same edge, so the output moves one clock after the inputs are presented. The memory array itself is not part of the block. The right port's mailbox is the top word (all address bits one, 0x3FF by default). The left port's mailbox is the word just below it (0x3FE).

Top module: `mbox_irq`

## Requirements
- R1: While rst_n is low, both l_irq_n and r_irq_n are high. Both stay high after reset until a qualified set occurs.
- R2: A left-port write to 0x3FF drives r_irq_n low from the next edge on. A write is l_cs_n=0 and l_wr_n=0 at a clock edge.
- R3: A right-port read of 0x3FF drives r_irq_n high from the next edge on. A read is r_cs_n=0, r_wr_n=1 and r_oe_n=0 at a clock edge.
- R4: A right-port write to 0x3FE (r_cs_n=0, r_wr_n=0) drives l_irq_n low from the next edge on.
- R5: A left-port read of 0x3FE (l_cs_n=0, l_wr_n=1, l_oe_n=0) drives l_irq_n high from the next edge on.
- R6: An access with chip enable high has no effect on either flag. A read with output enable high also has no effect.
- R7: If a set and a clear reach the same flag at the same edge, the flag goes low (the set wins).
- R8: A port writing its own mailbox word leaves both flags unchanged. A port reading the other port's mailbox word also leaves both flags unchanged.
- R9: The two flags are independent. Each one changes only through its own set and clear rules, under any mix of accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_addr | input | ADDR_W | Left port word address |
| l_cs_n | input | 1 | Left port chip enable, active low |
| l_wr_n | input | 1 | Left port read/write: 0 = write, 1 = read |
| l_oe_n | input | 1 | Left port output enable, active low |
| r_addr | input | ADDR_W | Right port word address |
| r_cs_n | input | 1 | Right port chip enable, active low |
| r_wr_n | input | 1 | Right port read/write: 0 = write, 1 = read |
| r_oe_n | input | 1 | Right port output enable, active low |
| l_irq_n | output | 1 | Left port mailbox interrupt, active low |
| r_irq_n | output | 1 | Right port mailbox interrupt, active low |

## Verification
The assertions assume that every port input is settled at each rising clock edge. They also assume that one edge's sample represents a whole access, so a write or a read is counted once per cycle in which it is held. The stimulus meets both assumptions by changing inputs only on the falling edge. The random stimulus biases addresses toward the two mailbox words and draws each control bit freely. This makes simultaneous sets and clears, accesses with chip enable high, and writes with output enable low all occur often.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_cs_n,
  input  logic              l_wr_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_cs_n,
  input  logic              r_wr_n,
  input  logic              r_oe_n,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] L_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic l_wr, l_rd, r_wr, r_rd;
  logic set_r, clr_r, set_l, clr_l;

  assign l_wr  = !l_cs_n && !l_wr_n;
  assign l_rd  = !l_cs_n &&  l_wr_n && !l_oe_n;
  assign r_wr  = !r_cs_n && !r_wr_n;
  assign r_rd  = !r_cs_n &&  r_wr_n && !r_oe_n;

  assign set_r = l_wr && (l_addr == R_BOX);
  assign clr_r = r_rd && (r_addr == R_BOX);
  assign set_l = r_wr && (r_addr == L_BOX);
  assign clr_l = l_rd && (l_addr == L_BOX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_irq_n <= 1'b1;
      l_irq_n <= 1'b1;
    end else begin
      if (set_r)      r_irq_n <= 1'b0;
      else if (clr_r) r_irq_n <= 1'b1;
      if (set_l)      l_irq_n <= 1'b0;
      else if (clr_l) l_irq_n <= 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n));

  a_r2_left_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && !l_wr_n && l_addr == R_BOX) |=> !r_irq_n);

  a_r3_right_clears_right: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_r && !set_r) |=> r_irq_n);

  a_r4_right_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_cs_n && !r_wr_n && r_addr == L_BOX) |=> !l_irq_n);

  a_r5_left_clears_left: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_l && !set_l) |=> l_irq_n);

  a_r6_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_r && !clr_r) |=> $stable(r_irq_n));

  a_r6_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_l && !clr_l) |=> $stable(l_irq_n));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_r && clr_r) |=> !r_irq_n);

  a_r8_chip_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs_n && r_cs_n) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

// File: tb/mbox_irq_tb_top.sv
module mbox_irq_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam logic [AW-1:0] RB = 10'h3FF;
  localparam logic [AW-1:0] LB = 10'h3FE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_cs_n = 1'b1, l_wr_n = 1'b1, l_oe_n = 1'b1;
  logic r_cs_n = 1'b1, r_wr_n = 1'b1, r_oe_n = 1'b1;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic m_l = 1'b1, m_r = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  mbox_irq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_cs_n(l_cs_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n),
    .r_addr(r_addr), .r_cs_n(r_cs_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  function automatic logic nxt(logic cur, logic set, logic clr);
    return set ? 1'b0 : (clr ? 1'b1 : cur);
  endfunction

  task automatic chk(string tag, logic exp_l, logic exp_r);
    checks++;
    if (l_irq_n !== exp_l || r_irq_n !== exp_r) begin
      fails++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected l=%b r=%b",
               tag, l_irq_n, r_irq_n, exp_l, exp_r);
    end
  endtask

  task automatic drive(logic [AW-1:0] la, logic lc, logic lw, logic lo,
                       logic [AW-1:0] ra, logic rc, logic rw, logic ro);
    l_addr = la; l_cs_n = lc; l_wr_n = lw; l_oe_n = lo;
    r_addr = ra; r_cs_n = rc; r_wr_n = rw; r_oe_n = ro;
    @(posedge clk);
    m_r = nxt(m_r, !lc && !lw && la == RB, !rc && rw && !ro && ra == RB);
    m_l = nxt(m_l, !rc && !rw && ra == LB, !lc && lw && !lo && la == LB);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] pick();
    int k = $urandom % 8;
    if (k < 3) return RB;
    if (k < 6) return LB;
    return AW'($urandom);
  endfunction

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b1, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 1'b1, 1'b1);

    drive(RB,0,0,1, 0,1,1,1);   chk("R2 left write 3FF", 1, 0);
    drive(0,1,1,1, RB,0,0,1);   chk("R8 right writes own box", 1, 0);
    drive(0,1,1,1, RB,0,1,1);   chk("R6 read with oe high", 1, 0);
    drive(0,1,1,1, RB,1,1,0);   chk("R6 read with cs high", 1, 0);
    drive(0,1,1,1, RB,0,1,0);   chk("R3 right read 3FF", 1, 1);
    drive(0,1,1,1, LB,0,0,1);   chk("R4 right write 3FE", 0, 1);
    drive(RB,0,1,0, 0,1,1,1);   chk("R8 left reads other box", 0, 1);
    drive(LB,0,0,1, 0,1,1,1);   chk("R8 left writes own box", 0, 1);
    drive(LB,0,1,0, 0,1,1,1);   chk("R5 left read 3FE", 1, 1);
    drive(RB,1,0,1, 0,1,1,1);   chk("R6 write with cs high", 1, 1);
    drive(RB,0,0,0, RB,0,1,0);  chk("R7 set and clear right", 1, 0);
    drive(LB,0,1,0, LB,0,0,1);  chk("R7 set and clear left", 0, 0);
    drive(LB,0,1,0, 0,1,1,1);   chk("R9 clear left leaves right", 1, 0);
    drive(0,1,1,1, RB,0,1,0);   chk("R9 clear right leaves left", 1, 1);
    drive(10'h155,0,0,1, 10'h2AA,0,0,1); chk("R9 plain writes", 1, 1);

    for (int i = 0; i < 3000; i++) begin
      drive(pick(), 1'($urandom), 1'($urandom), 1'($urandom),
            pick(), 1'($urandom), 1'($urandom), 1'($urandom));
      chk("R9 random", m_l, m_r);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule